// File: doc/BRIEF.md
# Single-Entry Handshake Buffer Run-Time Monitor

This block is a passive, synthesizable observer placed next to a one-entry valid/ready buffer. It watches both sides of the buffer: the producer side (incoming word, producer valid, and the buffer's ready output) and the consumer side (the buffer's outgoing word and valid, and the consumer's ready). It does not drive the buffer. On every clock it judges the buffer's outputs against the contract such a buffer has to honour, and latches a separate sticky flag for each broken rule.

To do this it keeps its own occupancy count, built only from the handshakes it sees, and a copy of the word most recently accepted on the producer side. A word moves across a side in any cycle where that side's valid and ready are both high. A word may enter and leave in the same cycle, whether the buffer is empty or full. Rules that compare one cycle with the next use registered copies of the previous cycle. Those rules stay silent in the first cycle after power-up, because no history exists yet. A separate sticky flag records that the buffer was seen to go from holding a word to holding none.

Top module: `hs_buf_monitor`

## Requirements
- R1: The monitor's occupancy goes up by one on a producer-side transfer without a consumer-side transfer, down by one on the reverse, and stays the same when both or neither happen. Reset clears it to 0. A correct buffer exercised through fill, hold, simultaneous in/out while full, drain and idle raises no flag.
- R2: If reset was sampled high in one cycle and `dn_valid` is high in the next cycle, `viol[0]` is raised.
- R3: If `dn_valid` is high, `dn_ready` is low and reset is low in one cycle, and in the next cycle `dn_valid` or `dn_data` differs, `viol[1]` is raised.
- R4: If `up_ready` is high, `up_valid` is low and reset is low in one cycle, and in the next cycle `up_ready` differs, `viol[2]` is raised.
- R5: While the occupancy is 1 and reset is low, `dn_valid` low or `dn_data` unequal to the last accepted word raises `viol[4]`.
- R6: While the occupancy is 0 and reset is low, `dn_valid` high raises `viol[5]`.
- R7: An occupancy below 0 or above 1 raises `viol[3]`. This covers both a drain from empty and a second fill while full.
- R8: A violation in cycle N is visible on `viol` after the rising edge that ends cycle N. Each bit then stays set until a cycle with reset high, after which all bits and `cover_seen` read 0.
- R9: `cover_seen` is set after the edge that ends a cycle where `dn_valid` is low, following a cycle where `dn_valid` was high with reset low. It stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared with the buffer |
| rst | input | 1 | Synchronous active-high reset, same as the buffer's |
| up_data | input | DATA_W | Word offered by the producer |
| up_valid | input | 1 | Producer has a word |
| up_ready | input | 1 | Buffer's ready output toward the producer |
| dn_data | input | DATA_W | Buffer's word toward the consumer |
| dn_valid | input | 1 | Buffer's valid output toward the consumer |
| dn_ready | input | 1 | Consumer's ready |
| viol | output | 6 | Sticky rule flags: 0 after-reset, 1 hold, 2 ready-hold, 3 range, 4 full, 5 empty |
| cover_seen | output | 1 | Sticky flag: full-to-empty transition seen |

## Verification
The range, full and empty rules judge the current cycle. Their flags are due one edge after the offending cycle. The after-reset, hold and ready-hold rules compare a cycle with the one before it, so their flags appear one edge after the second cycle of that pair. The coverage flag follows the same pattern. The bench drives each cycle at the falling edge and reads the flags at the next falling edge. This means every check falls exactly one rising edge after the cycle the rule judges. Cases where one fault trips two rules expect both bits together.

// File: rtl/hs_buf_monitor_pkg.sv
package hs_buf_monitor_pkg;

    typedef enum int unsigned {
        RULE_AFTER_RST = 0,
        RULE_OUT_HOLD  = 1,
        RULE_RDY_HOLD  = 2,
        RULE_RANGE     = 3,
        RULE_FULL      = 4,
        RULE_EMPTY     = 5
    } rule_e;

    localparam int unsigned NUM_RULES = 6;

    // Handshake bits seen on both sides in one cycle
    typedef struct packed {
        logic up_valid;
        logic up_ready;
        logic dn_valid;
        logic dn_ready;
    } hs_bits_t;

    function automatic logic moves_in(input hs_bits_t h);
        return h.up_valid & h.up_ready;
    endfunction

    function automatic logic moves_out(input hs_bits_t h);
        return h.dn_valid & h.dn_ready;
    endfunction

endpackage

// File: rtl/hs_buf_monitor_history.sv
module hs_buf_monitor_history
    import hs_buf_monitor_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  hs_bits_t          hs_now,
    input  logic [DATA_W-1:0] dn_data_now,
    output hs_bits_t          hs_prev,
    output logic [DATA_W-1:0] dn_data_prev,
    output logic              rst_prev,
    output logic              hist_ok
);
    logic hist_ok_q = 1'b0;

    always_ff @(posedge clk) begin
        hs_prev      <= hs_now;
        dn_data_prev <= dn_data_now;
        rst_prev     <= rst;
        hist_ok_q    <= 1'b1;
    end

    assign hist_ok = hist_ok_q;

endmodule

// File: rtl/hs_buf_monitor_occupancy.sv
module hs_buf_monitor_occupancy
    import hs_buf_monitor_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OCC_W  = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  hs_bits_t                hs_now,
    input  logic [DATA_W-1:0]       up_data,
    output logic signed [OCC_W-1:0] occ,
    output logic [DATA_W-1:0]       last_word
);
    localparam logic signed [OCC_W-1:0] OCC_HI = {1'b0, {(OCC_W-1){1'b1}}};
    localparam logic signed [OCC_W-1:0] OCC_LO = {1'b1, {(OCC_W-1){1'b0}}};

    logic in_x, out_x;

    always_comb begin
        in_x  = moves_in(hs_now);
        out_x = moves_out(hs_now);
    end

    // Saturating count so an out-of-range value stays out of range
    always_ff @(posedge clk) begin
        if (rst) begin
            occ <= '0;
        end else if (in_x && !out_x && occ != OCC_HI) begin
            occ <= occ + 1'b1;
        end else if (out_x && !in_x && occ != OCC_LO) begin
            occ <= occ - 1'b1;
        end
    end

    // Capture is intentionally outside reset
    always_ff @(posedge clk) begin
        if (in_x) begin
            last_word <= up_data;
        end
    end

endmodule

// File: rtl/hs_buf_monitor_rules.sv
module hs_buf_monitor_rules
    import hs_buf_monitor_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OCC_W  = 3
) (
    input  logic                    rst,
    input  hs_bits_t                hs_now,
    input  logic [DATA_W-1:0]       dn_data_now,
    input  hs_bits_t                hs_prev,
    input  logic [DATA_W-1:0]       dn_data_prev,
    input  logic                    rst_prev,
    input  logic                    hist_ok,
    input  logic signed [OCC_W-1:0] occ,
    input  logic [DATA_W-1:0]       last_word,
    output logic [NUM_RULES-1:0]    hit,
    output logic                    cover_hit
);
    localparam logic signed [OCC_W-1:0] OCC_ZERO = '0;
    localparam logic signed [OCC_W-1:0] OCC_ONE  = {{(OCC_W-1){1'b0}}, 1'b1};

    logic out_waiting_prev, rdy_idle_prev, out_changed, rdy_changed;

    always_comb begin
        out_waiting_prev = hist_ok && !rst_prev && hs_prev.dn_valid && !hs_prev.dn_ready;
        rdy_idle_prev    = hist_ok && !rst_prev && hs_prev.up_ready && !hs_prev.up_valid;
        out_changed      = (hs_now.dn_valid != hs_prev.dn_valid) || (dn_data_now != dn_data_prev);
        rdy_changed      = hs_now.up_ready != hs_prev.up_ready;

        hit = '0;
        hit[RULE_AFTER_RST] = hist_ok && rst_prev && hs_now.dn_valid;
        hit[RULE_OUT_HOLD]  = out_waiting_prev && out_changed;
        hit[RULE_RDY_HOLD]  = rdy_idle_prev && rdy_changed;
        hit[RULE_RANGE]     = !rst && ((occ < OCC_ZERO) || (occ > OCC_ONE));
        hit[RULE_FULL]      = !rst && (occ == OCC_ONE) &&
                              (!hs_now.dn_valid || (dn_data_now != last_word));
        hit[RULE_EMPTY]     = !rst && (occ == OCC_ZERO) && hs_now.dn_valid;

        cover_hit = hist_ok && !rst_prev && hs_prev.dn_valid && !hs_now.dn_valid;
    end

endmodule

// File: rtl/hs_buf_monitor_sticky.sv
module hs_buf_monitor_sticky #(
    parameter int unsigned N = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_in,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                flags[i] <= 1'b0;
            end else if (set_in[i]) begin
                flags[i] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/hs_buf_monitor.sv
module hs_buf_monitor
    import hs_buf_monitor_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned OCC_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DATA_W-1:0]    up_data,
    input  logic                 up_valid,
    input  logic                 up_ready,
    input  logic [DATA_W-1:0]    dn_data,
    input  logic                 dn_valid,
    input  logic                 dn_ready,
    output logic [NUM_RULES-1:0] viol,
    output logic                 cover_seen
);
    localparam int unsigned FLAG_N = NUM_RULES + 1;

    hs_bits_t                hs_now, hs_prev;
    logic [DATA_W-1:0]       dn_data_prev, last_word;
    logic                    rst_prev, hist_ok, cover_hit;
    logic signed [OCC_W-1:0] occ;
    logic [NUM_RULES-1:0]    hit;
    logic [FLAG_N-1:0]       flag_set, flag_q;

    always_comb begin
        hs_now.up_valid = up_valid;
        hs_now.up_ready = up_ready;
        hs_now.dn_valid = dn_valid;
        hs_now.dn_ready = dn_ready;
    end

    hs_buf_monitor_history #(.DATA_W(DATA_W)) u_hist (
        .clk          (clk),
        .rst          (rst),
        .hs_now       (hs_now),
        .dn_data_now  (dn_data),
        .hs_prev      (hs_prev),
        .dn_data_prev (dn_data_prev),
        .rst_prev     (rst_prev),
        .hist_ok      (hist_ok)
    );

    hs_buf_monitor_occupancy #(.DATA_W(DATA_W), .OCC_W(OCC_W)) u_occ (
        .clk       (clk),
        .rst       (rst),
        .hs_now    (hs_now),
        .up_data   (up_data),
        .occ       (occ),
        .last_word (last_word)
    );

    hs_buf_monitor_rules #(.DATA_W(DATA_W), .OCC_W(OCC_W)) u_rules (
        .rst          (rst),
        .hs_now       (hs_now),
        .dn_data_now  (dn_data),
        .hs_prev      (hs_prev),
        .dn_data_prev (dn_data_prev),
        .rst_prev     (rst_prev),
        .hist_ok      (hist_ok),
        .occ          (occ),
        .last_word    (last_word),
        .hit          (hit),
        .cover_hit    (cover_hit)
    );

    assign flag_set = {cover_hit, hit};

    hs_buf_monitor_sticky #(.N(FLAG_N)) u_sticky (
        .clk    (clk),
        .rst    (rst),
        .set_in (flag_set),
        .flags  (flag_q)
    );

    assign viol       = flag_q[NUM_RULES-1:0];
    assign cover_seen = flag_q[NUM_RULES];

endmodule

// File: rtl/hs_buf_monitor_chk.sv
module hs_buf_monitor_chk
    import hs_buf_monitor_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 up_valid,
    input logic                 up_ready,
    input logic [DATA_W-1:0]    dn_data,
    input logic                 dn_valid,
    input logic                 dn_ready,
    input logic [NUM_RULES-1:0] viol,
    input logic                 cover_seen
);
    // R8: reset leaves every flag clear
    a_r8_reset_clears: assert property (@(posedge clk)
        rst |=> (viol == '0 && !cover_seen));

    // R8: flags never drop outside reset
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((viol & $past(viol)) == $past(viol)));

    // R2: output valid right after reset gets flagged
    a_r2_after_reset: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && dn_valid) |=> viol[RULE_AFTER_RST]);

    // R3: waiting output that drops valid gets flagged
    a_r3_out_hold: assert property (@(posedge clk) disable iff (rst)
        (dn_valid && !dn_ready ##1 !dn_valid) |=> viol[RULE_OUT_HOLD]);

    // R4: idle ready that drops gets flagged
    a_r4_rdy_hold: assert property (@(posedge clk) disable iff (rst)
        (up_ready && !up_valid ##1 !up_ready) |=> viol[RULE_RDY_HOLD]);

    // R9: valid-high then valid-low sets the coverage flag
    a_r9_cover: assert property (@(posedge clk) disable iff (rst)
        (dn_valid ##1 !dn_valid) |=> cover_seen);

endmodule

bind hs_buf_monitor hs_buf_monitor_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .up_valid   (up_valid),
    .up_ready   (up_ready),
    .dn_data    (dn_data),
    .dn_valid   (dn_valid),
    .dn_ready   (dn_ready),
    .viol       (viol),
    .cover_seen (cover_seen)
);

// File: tb/hs_buf_monitor_tb.sv
module hs_buf_monitor_tb;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [DW-1:0] up_data, dn_data;
    logic          up_valid, up_ready, dn_valid, dn_ready;
    logic [5:0]    viol;
    logic          cover_seen;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    localparam logic [5:0] B_RST = 6'b000001, B_HOLD = 6'b000010, B_RDY = 6'b000100,
                           B_RANGE = 6'b001000, B_FULL = 6'b010000, B_EMPTY = 6'b100000;

    always #2 clk = ~clk;

    hs_buf_monitor #(.DATA_W(DW), .OCC_W(3)) u_dut (
        .clk (clk), .rst (rst),
        .up_data (up_data), .up_valid (up_valid), .up_ready (up_ready),
        .dn_data (dn_data), .dn_valid (dn_valid), .dn_ready (dn_ready),
        .viol (viol), .cover_seen (cover_seen)
    );

    task automatic cyc(input logic [DW-1:0] ud, input logic uv, input logic ur,
                       input logic [DW-1:0] dd, input logic dv, input logic dr);
        up_data = ud; up_valid = uv; up_ready = ur;
        dn_data = dd; dn_valid = dv; dn_ready = dr;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_flags(input logic [5:0] ev, input logic ec, input string req);
        checks++;
        if (viol !== ev || cover_seen !== ec) begin
            errors++;
            $display("FAIL %s: actual viol=%b cover=%b expected viol=%b cover=%b",
                     req, viol, cover_seen, ev, ec);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cyc(8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        cyc(8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        rst = 1'b0;
        expect_flags(6'b0, 1'b0, "R8 reset state");
    endtask

    // R1, R9: correct buffer traffic, then drain to empty
    task automatic t_clean_traffic();
        do_reset();
        cyc(8'h5A, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0); // fill
        cyc(8'h00, 1'b0, 1'b0, 8'h5A, 1'b1, 1'b0); // hold, consumer stalls
        expect_flags(6'b0, 1'b0, "R1 fill/hold");
        cyc(8'h33, 1'b1, 1'b1, 8'h5A, 1'b1, 1'b1); // in and out while full
        cyc(8'h00, 1'b0, 1'b1, 8'h33, 1'b1, 1'b1); // drain
        expect_flags(6'b0, 1'b0, "R1 simultaneous in/out");
        cyc(8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0); // empty idle
        expect_flags(6'b0, 1'b1, "R9 full-to-empty cover");
        cyc(8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0);
        expect_flags(6'b0, 1'b1, "R1 idle stays clean");
    endtask

    // R2, R6: valid right after reset
    task automatic t_after_reset();
        do_reset();
        cyc(8'h00, 1'b0, 1'b0, 8'h77, 1'b1, 1'b0);
        expect_flags(B_RST | B_EMPTY, 1'b0, "R2 valid after reset");
    endtask

    // R3, R5: waiting output drops valid
    task automatic t_out_hold();
        do_reset();
        cyc(8'h11, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0);
        cyc(8'h00, 1'b0, 1'b0, 8'h11, 1'b1, 1'b0);
        expect_flags(6'b0, 1'b0, "R3 before drop");
        cyc(8'h00, 1'b0, 1'b0, 8'h11, 1'b0, 1'b0);
        expect_flags(B_HOLD | B_FULL, 1'b1, "R3 valid dropped while waiting");
    endtask

    // R3: waiting output changes its data
    task automatic t_out_data_change();
        do_reset();
        cyc(8'h21, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0);
        cyc(8'h00, 1'b0, 1'b0, 8'h21, 1'b1, 1'b0);
        cyc(8'h00, 1'b0, 1'b0, 8'h22, 1'b1, 1'b0);
        expect_flags(B_HOLD | B_FULL, 1'b0, "R3 data changed while waiting");
    endtask

    // R5: wrong word presented while full
    task automatic t_full_mismatch();
        do_reset();
        cyc(8'h11, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0);
        cyc(8'h00, 1'b0, 1'b1, 8'h22, 1'b1, 1'b1);
        expect_flags(B_FULL, 1'b0, "R5 data differs from last accepted");
    endtask

    // R4, R8: ready withdrawn while idle, then sticky, then cleared
    task automatic t_ready_hold();
        do_reset();
        cyc(8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b0);
        expect_flags(6'b0, 1'b0, "R4 before drop");
        cyc(8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        expect_flags(B_RDY, 1'b0, "R4 ready dropped without transfer");
        for (int i = 0; i < 3; i++) cyc(8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        expect_flags(B_RDY, 1'b0, "R8 flag stays set");
        do_reset();
    endtask

    // R6, R7, R9: drain from empty
    task automatic t_underflow();
        do_reset();
        cyc(8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        cyc(8'h00, 1'b0, 1'b0, 8'h44, 1'b1, 1'b1);
        expect_flags(B_EMPTY, 1'b0, "R6 valid while empty");
        cyc(8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        expect_flags(B_EMPTY | B_RANGE, 1'b1, "R7 occupancy below zero");
    endtask

    // R5, R7: second fill while full
    task automatic t_overflow();
        do_reset();
        cyc(8'h01, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0);
        cyc(8'h02, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0);
        expect_flags(B_FULL, 1'b0, "R5 no valid while full");
        cyc(8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        expect_flags(B_FULL | B_RANGE, 1'b0, "R7 occupancy above one");
    endtask

    initial begin
        rst = 1'b1;
        up_data = '0; up_valid = 1'b0; up_ready = 1'b0;
        dn_data = '0; dn_valid = 1'b0; dn_ready = 1'b0;
        @(negedge clk);
        t_clean_traffic();
        t_after_reset();
        t_out_hold();
        t_out_data_change();
        t_full_mismatch();
        t_ready_hold();
        t_underflow();
        t_overflow();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule